// File: doc/BRIEF.md
# Two-Level Address Translation Walker with TLB

The block turns a 32-bit linear address into a physical address. It first searches a small fully associative translation cache. On a hit the answer is ready one cycle after the request. On a miss it walks a two-level table in memory through a read port that has one read outstanding at a time. The first read fetches a directory entry. That entry either maps a 4 MB page on its own, which ends the walk, or points to a table of 4 KB pages, which needs a second read. A successful walk writes the result into the cache. A missing entry at either level returns a page fault.

Software loads the base frame of the directory through a write strobe. A flush input empties the cache in one cycle. A new request is taken only while `reqReady` is high. Each request produces exactly one response pulse on `rspValid`, which carries either a physical address or a fault.

Top module: `xlat_walker`

## Requirements
- R1: After reset `rspValid` and `memReq` are low, `reqReady` is high, and the cache holds no valid entry, so the first lookup of any address walks memory.
- R2: A request that hits the cache gives `rspValid` one cycle after acceptance with `rspFault` low and no memory read. For a 4 KB entry `rspPhys` is {frame[19:0], va[11:0]}. For a 4 MB entry it is {frame[19:10], va[21:0]}.
- R3: On a miss the first read goes to {dirBase[19:0], va[31:22], 2'b00}. In every entry read from memory, bit 0 means present and bit 1 means large page.
- R4: A present directory entry with bit 1 clear causes a second read at {entry[31:12], va[21:12], 2'b00}. A present table entry gives `rspPhys` = {entry[31:12], va[11:0]} one cycle after its read data arrives.
- R5: A present directory entry with bit 1 set ends the walk after one read. `rspPhys` = {entry[31:22], va[21:0]} one cycle after the read data.
- R6: A clear present bit at either level gives `rspValid` with `rspFault` high and `rspPhys` zero one cycle after the read data. The cache is left unchanged, so the same address walks again.
- R7: A successful walk fills the cache and records the page size. A 4 MB entry then hits for every address inside its 4 MB region.
- R8: The cache has 32 entries filled in round-robin order. After 32 further fills the oldest entry has been replaced and misses again.
- R9: `flush` invalidates every entry in one cycle. When it coincides with a fill, the fill is dropped and the round-robin position does not move. The response of that walk is still delivered.
- R10: `memReq` stays high with a stable `memAddr` until `memRspValid` is seen. While a walk is in progress `reqReady` is low and `reqValid` is ignored.
- R11: A pulse on `dirBaseWe` loads `dirBaseIn` as the directory base frame used by all later walks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dirBaseWe | input | 1 | Load strobe for the directory base |
| dirBaseIn | input | 20 | Directory base frame number |
| flush | input | 1 | Invalidate all cache entries |
| reqValid | input | 1 | Translation request |
| reqReady | output | 1 | Block is idle and accepts a request |
| reqAddr | input | 32 | Linear address to translate |
| rspValid | output | 1 | One-cycle response pulse |
| rspFault | output | 1 | Response is a page fault |
| rspPhys | output | 32 | Translated physical address |
| memReq | output | 1 | Memory read pending |
| memAddr | output | 32 | Memory read byte address |
| memRspValid | input | 1 | Read data valid, accepted while memReq is high |
| memRspData | input | 32 | Read data (table entry) |

## Verification
A hit answers one cycle after acceptance. A miss raises `memReq` in the cycle after acceptance, and its final answer comes one cycle after the clock edge that takes the last read data. A two-level walk raises `memReq` again for the table read in the cycle after the directory data. The bench drives inputs and samples outputs on falling edges. It runs a behavioural model (entry arrays, a round-robin index and a memory image) that tells each walk which of these cycles to expect. In every cycle it compares `rspValid`, `memReq` and `memAddr`, and it compares the fault and address on the response cycle.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W      = 32;
  localparam int OFF_W     = 12;
  localparam int IDX_W     = 10;
  localparam int VPN_W     = VA_W - OFF_W;
  localparam int BIG_OFF_W = OFF_W + IDX_W;
  localparam int PRESENT_BIT = 0;
  localparam int LARGE_BIT   = 1;

  typedef enum logic [1:0] {ST_IDLE, ST_DIR, ST_TBL} walkState_t;

  typedef struct packed {
    logic latchVa;
    logic rspHit;
    logic rspFault;
    logic fillBig;
    logic fillSmall;
    logic latchPde;
    logic ptePhase;
  } xlatStrobe_t;
endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        tlbHit,
  input  logic        memRspValid,
  input  logic        entPresent,
  input  logic        entLarge,
  output logic        reqReady,
  output logic        memReq,
  output xlatStrobe_t stb
);
  walkState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stb       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (tlbHit) stb.rspHit = 1'b1;
          else begin
            stb.latchVa = 1'b1;
            stateNext   = ST_DIR;
          end
        end
      end
      ST_DIR: begin
        if (memRspValid) begin
          if (!entPresent) begin
            stb.rspFault = 1'b1;
            stateNext    = ST_IDLE;
          end else if (entLarge) begin
            stb.fillBig = 1'b1;
            stateNext   = ST_IDLE;
          end else begin
            stb.latchPde = 1'b1;
            stateNext    = ST_TBL;
          end
        end
      end
      ST_TBL: begin
        stb.ptePhase = 1'b1;
        if (memRspValid) begin
          if (entPresent) stb.fillSmall = 1'b1;
          else            stb.rspFault  = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqReady = (state == ST_IDLE);
  assign memReq   = (state != ST_IDLE);

  // R10: a pending read is held until its data arrives
  p_memreq_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memRspValid |=> memReq);

  // R4: a directory pointer entry always leads to a table read
  p_table_follows_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.latchPde |=> (memReq && state == ST_TBL));
endmodule

// File: rtl/xlat_dp.sv
module xlat_dp
  import xlat_pkg::*;
#(
  parameter  int TLB_N = 32,
  localparam int PTR_W = (TLB_N > 1) ? $clog2(TLB_N) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             dirBaseWe,
  input  logic [VPN_W-1:0] dirBaseIn,
  input  logic [VA_W-1:0]  reqAddr,
  input  logic [VA_W-1:0]  memRspData,
  input  xlatStrobe_t      stb,
  output logic             tlbHit,
  output logic             entPresent,
  output logic             entLarge,
  output logic [VA_W-1:0]  memAddr,
  output logic             rspValid,
  output logic             rspFault,
  output logic [VA_W-1:0]  rspPhys
);
  logic [VPN_W-1:0] dirBase;
  logic [VA_W-1:0]  vaReg;
  logic [VPN_W-1:0] pdeFrame;

  logic [TLB_N-1:0] vld;
  logic [TLB_N-1:0] big;
  logic [VPN_W-1:0] tag [TLB_N];
  logic [VPN_W-1:0] pfn [TLB_N];
  logic [PTR_W-1:0] ptr;

  logic [TLB_N-1:0] match;
  logic [PTR_W-1:0] hitIdx;
  logic [VA_W-1:0]  hitPhys;
  logic [VA_W-1:0]  fillPhys;
  logic [VPN_W-1:0] fillPfn;
  logic             fillAny;
  logic             doFill;
  logic             unusedBits;

  assign entPresent = memRspData[PRESENT_BIT];
  assign entLarge   = memRspData[LARGE_BIT];
  assign unusedBits = ^memRspData[OFF_W-1:LARGE_BIT+1];

  // directory base register and walk context
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirBase  <= '0;
      vaReg    <= '0;
      pdeFrame <= '0;
    end else begin
      if (dirBaseWe)    dirBase  <= dirBaseIn;
      if (stb.latchVa)  vaReg    <= reqAddr;
      if (stb.latchPde) pdeFrame <= memRspData[VA_W-1:OFF_W];
    end
  end

  assign memAddr = stb.ptePhase
    ? {pdeFrame, vaReg[BIG_OFF_W-1:OFF_W], 2'b00}
    : {dirBase, vaReg[VA_W-1:BIG_OFF_W], 2'b00};

  // associative compare, one comparator per entry
  for (genvar g = 0; g < TLB_N; g++) begin : g_cmp
    always_comb begin
      if (big[g])
        match[g] = vld[g] && (tag[g][VPN_W-1:IDX_W] == reqAddr[VA_W-1:BIG_OFF_W]);
      else
        match[g] = vld[g] && (tag[g] == reqAddr[VA_W-1:OFF_W]);
    end
  end

  always_comb begin
    hitIdx = '0;
    for (int i = TLB_N - 1; i >= 0; i--)
      if (match[i]) hitIdx = PTR_W'(i);
  end

  assign tlbHit  = |match;
  assign hitPhys = big[hitIdx]
    ? {pfn[hitIdx][VPN_W-1:IDX_W], reqAddr[BIG_OFF_W-1:0]}
    : {pfn[hitIdx], reqAddr[OFF_W-1:0]};

  // fill path
  assign fillAny  = stb.fillBig || stb.fillSmall;
  assign doFill   = fillAny && !flush;
  assign fillPfn  = stb.fillBig
    ? {memRspData[VA_W-1:BIG_OFF_W], {IDX_W{1'b0}}}
    : memRspData[VA_W-1:OFF_W];
  assign fillPhys = stb.fillBig
    ? {memRspData[VA_W-1:BIG_OFF_W], vaReg[BIG_OFF_W-1:0]}
    : {memRspData[VA_W-1:OFF_W], vaReg[OFF_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vld <= '0;
      ptr <= '0;
    end else if (flush) begin
      vld <= '0;
    end else if (doFill) begin
      vld[ptr] <= 1'b1;
      ptr      <= (ptr == PTR_W'(TLB_N - 1)) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doFill) begin
      big[ptr] <= stb.fillBig;
      tag[ptr] <= vaReg[VA_W-1:OFF_W];
      pfn[ptr] <= fillPfn;
    end
  end

  // response register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspFault <= 1'b0;
      rspPhys  <= '0;
    end else begin
      rspValid <= stb.rspHit || stb.rspFault || fillAny;
      rspFault <= stb.rspFault;
      if (stb.rspHit)        rspPhys <= hitPhys;
      else if (fillAny)      rspPhys <= fillPhys;
      else if (stb.rspFault) rspPhys <= '0;
    end
  end

  // R9: one cycle after a flush no entry remains valid
  p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (vld == '0));

  // R6: a fault carries no address
  p_fault_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspFault |-> (rspPhys == '0));

  // R2: a hit answers in the next cycle without a fault
  p_hit_resp_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.rspHit |=> (rspValid && !rspFault));

  // R6: a fault leaves the entry valid bits untouched
  p_fault_keeps_tlb_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.rspFault && !flush |=> $stable(vld));
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int TLB_N = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        dirBaseWe,
  input  logic [19:0] dirBaseIn,
  input  logic        flush,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [31:0] reqAddr,
  output logic        rspValid,
  output logic        rspFault,
  output logic [31:0] rspPhys,
  output logic        memReq,
  output logic [31:0] memAddr,
  input  logic        memRspValid,
  input  logic [31:0] memRspData
);
  xlatStrobe_t stb;
  logic        tlbHit;
  logic        entPresent;
  logic        entLarge;

  xlat_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .tlbHit(tlbHit),
    .memRspValid(memRspValid), .entPresent(entPresent), .entLarge(entLarge),
    .reqReady(reqReady), .memReq(memReq), .stb(stb)
  );

  xlat_dp #(.TLB_N(TLB_N)) u_dp (
    .clk(clk), .rstN(rstN), .flush(flush), .dirBaseWe(dirBaseWe),
    .dirBaseIn(dirBaseIn), .reqAddr(reqAddr), .memRspData(memRspData),
    .stb(stb), .tlbHit(tlbHit), .entPresent(entPresent), .entLarge(entLarge),
    .memAddr(memAddr), .rspValid(rspValid), .rspFault(rspFault),
    .rspPhys(rspPhys)
  );

  // R10: the read address does not move while a read is pending
  p_memaddr_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReq && $past(memReq) && !$past(memRspValid) |-> $stable(memAddr));
endmodule

// File: tb/xlat_walker_test.sv
module xlat_walker_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dirBaseWe = 1'b0;
  logic [19:0] dirBaseIn = '0;
  logic        flush = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic        rspValid, rspFault;
  logic [31:0] rspPhys;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  xlat_walker uut (
    .clk(clk), .rstN(rstN), .dirBaseWe(dirBaseWe), .dirBaseIn(dirBaseIn),
    .flush(flush), .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .rspValid(rspValid), .rspFault(rspFault), .rspPhys(rspPhys),
    .memReq(memReq), .memAddr(memAddr), .memRspValid(memRspValid),
    .memRspData(memRspData)
  );

  // behavioural model state
  bit          mVld [32];
  bit          mBig [32];
  logic [19:0] mTag [32];
  logic [19:0] mPfn [32];
  int          mPtr = 0;
  logic [19:0] mBase = '0;
  logic [31:0] memImg [logic [31:0]];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return memImg.exists(a) ? memImg[a] : 32'h0;
  endfunction

  function automatic bit mLookup(input logic [31:0] va, output logic [31:0] pa);
    pa = '0;
    for (int i = 0; i < 32; i++) begin
      if (mVld[i] && (mBig[i] ? (mTag[i][19:10] == va[31:22]) : (mTag[i] == va[31:12]))) begin
        pa = mBig[i] ? {mPfn[i][19:10], va[21:0]} : {mPfn[i], va[11:0]};
        return 1'b1;
      end
    end
    return 1'b0;
  endfunction

  task automatic mFill(input logic [31:0] va, input bit isBig, input logic [19:0] frame);
    mVld[mPtr] = 1'b1; mBig[mPtr] = isBig; mTag[mPtr] = va[31:12]; mPfn[mPtr] = frame;
    mPtr = (mPtr + 1) % 32;
  endtask

  task automatic mFlush();
    for (int i = 0; i < 32; i++) mVld[i] = 1'b0;
  endtask

  // wait lat cycles with the read pending, then return data
  task automatic serveRead(input logic [31:0] expAddr, input int lat, input logic [31:0] data,
                           input bit flushNow, input bit poke, input string req);
    chk(memReq === 1'b1, req, {31'b0, memReq}, 32'h1);
    chk(memAddr === expAddr, req, memAddr, expAddr);
    chk(rspValid === 1'b0, req, {31'b0, rspValid}, 32'h0);
    for (int w = 0; w < lat; w++) begin
      if (poke && w == 0) begin
        chk(reqReady === 1'b0, "R10", {31'b0, reqReady}, 32'h0);
        reqValid = 1'b1; reqAddr = 32'hFFFF_F000;
      end
      @(negedge clk);
      reqValid = 1'b0;
      chk(memReq === 1'b1 && memAddr === expAddr, "R10", memAddr, expAddr);
      chk(rspValid === 1'b0, "R10", {31'b0, rspValid}, 32'h0);
    end
    memRspValid = 1'b1; memRspData = data; flush = flushNow;
    @(negedge clk);
    memRspValid = 1'b0; memRspData = '0; flush = 1'b0;
  endtask

  task automatic expectRsp(input bit f, input logic [31:0] pa, input string req);
    chk(rspValid === 1'b1, req, {31'b0, rspValid}, 32'h1);
    chk(rspFault === f, req, {31'b0, rspFault}, {31'b0, f});
    chk(rspPhys === pa, req, rspPhys, pa);
    chk(memReq === 1'b0, req, {31'b0, memReq}, 32'h0);
  endtask

  task automatic translate(input logic [31:0] va, input int lat, input bit flushEnd,
                           input bit poke, input string req);
    logic [31:0] pa, dirA, pde, tblA, pte;
    bit hit;
    hit = mLookup(va, pa);
    reqValid = 1'b1; reqAddr = va;
    @(negedge clk);
    reqValid = 1'b0;
    if (hit) begin
      expectRsp(1'b0, pa, req);
    end else begin
      chk(rspValid === 1'b0, req, {31'b0, rspValid}, 32'h0);
      dirA = {mBase, va[31:22], 2'b00};
      pde  = rd(dirA);
      if (!pde[0]) begin
        serveRead(dirA, lat, pde, flushEnd, poke, req);
        if (flushEnd) mFlush();
        expectRsp(1'b1, 32'h0, req);
      end else if (pde[1]) begin
        serveRead(dirA, lat, pde, flushEnd, poke, req);
        if (flushEnd) mFlush(); else mFill(va, 1'b1, {pde[31:22], 10'b0});
        expectRsp(1'b0, {pde[31:22], va[21:0]}, req);
      end else begin
        serveRead(dirA, lat, pde, 1'b0, poke, req);
        tblA = {pde[31:12], va[21:12], 2'b00};
        pte  = rd(tblA);
        serveRead(tblA, lat, pte, flushEnd, 1'b0, req);
        if (flushEnd) mFlush();
        else if (pte[0]) mFill(va, 1'b0, pte[31:12]);
        if (pte[0]) expectRsp(1'b0, {pte[31:12], va[11:0]}, req);
        else        expectRsp(1'b1, 32'h0, req);
      end
    end
    @(negedge clk);
    chk(rspValid === 1'b0, req, {31'b0, rspValid}, 32'h0);
  endtask

  // expect a walk for va (miss), verified by memReq after acceptance
  task automatic expectMiss(input logic [31:0] va, input string req);
    logic [31:0] pa;
    chk(mLookup(va, pa) == 1'b0, {req, " model"}, 32'h1, 32'h0);
    translate(va, 1, 1'b0, 1'b0, req);
  endtask

  task automatic setBase(input logic [19:0] b);
    dirBaseWe = 1'b1; dirBaseIn = b;
    @(negedge clk);
    dirBaseWe = 1'b0;
    mBase = b;
  endtask

  initial begin
    logic [31:0] pa;
    for (int i = 0; i < 32; i++) mVld[i] = 1'b0;
    // memory image: directory at frame 0x00010
    memImg[32'h0001_0004] = 32'h0002_0001;           // dir 1 -> table at 0x20000
    memImg[32'h0001_0008] = 32'h00C0_0003;           // dir 2 -> 4 MB frame 0x00C00000
    memImg[32'h0001_000C] = 32'h0000_0000;           // dir 3 absent
    for (int i = 0; i < 48; i++)
      memImg[32'h0002_0000 + 32'(i * 4)] = (32'(32'h500 + i) << 12) | 32'h1;
    memImg[32'h0002_0000 + 32'(50 * 4)] = 32'h0;     // table entry 50 absent
    memImg[32'h0003_0004] = 32'h0400_0003;           // alternate directory, dir 1 large

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rspValid === 1'b0, "R1", {31'b0, rspValid}, 32'h0);
    chk(memReq === 1'b0, "R1", {31'b0, memReq}, 32'h0);
    chk(reqReady === 1'b1, "R1", {31'b0, reqReady}, 32'h1);

    setBase(20'h00010);                                // R11
    expectMiss(32'h0040_1234, "R1");                   // R1 R3 R4 first lookup walks
    translate(32'h0040_1234, 1, 1'b0, 1'b0, "R2");     // R2 R7 hit
    translate(32'h0080_2345, 2, 1'b0, 1'b0, "R5");     // R5 large page
    translate(32'h00BF_FFF0, 1, 1'b0, 1'b0, "R7");     // R7 same 4 MB region hits
    translate(32'h00C0_0000, 2, 1'b0, 1'b0, "R6");     // R6 directory fault
    expectMiss(32'h00C0_0000, "R6");                   // R6 cache unchanged
    translate(32'h0043_2000, 3, 1'b0, 1'b0, "R6");     // R6 table fault (index 50)
    expectMiss(32'h0043_2000, "R6");
    translate(32'h0040_5ABC, 3, 1'b0, 1'b1, "R10");    // R10 ignored request mid-walk
    translate(32'h0040_5ABC, 1, 1'b0, 1'b0, "R10");    // result of original address cached

    // R9 standalone flush
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    mFlush();
    expectMiss(32'h0040_1234, "R9");
    // R9 flush coincides with a fill
    translate(32'h0040_2000, 1, 1'b1, 1'b0, "R9");
    expectMiss(32'h0040_2000, "R9");

    // R8 round robin: 33 fresh fills after a flush
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    mFlush();
    for (int i = 0; i < 33; i++)
      translate(32'h0040_0000 + 32'(i << 12), 1, 1'b0, 1'b0, "R8");
    expectMiss(32'h0040_0000, "R8");                   // oldest replaced
    chk(mLookup(32'h0040_2000, pa), "R8 model", 32'h0, 32'h1);
    translate(32'h0040_2000, 1, 1'b0, 1'b0, "R8");     // still resident

    // R11 new directory base
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    mFlush();
    setBase(20'h00030);
    translate(32'h0041_1111, 2, 1'b0, 1'b0, "R11");
    translate(32'h007F_0000, 1, 1'b0, 1'b0, "R11");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule